// File: doc/BRIEF.md
# Impedance Calibration Controller

The block tunes the strength codes of I/O drivers and on-die termination against two off-chip precision resistors, one tied to the supply and one to ground. Two legs, pull-up and pull-down, are handled side by side. Each leg puts a trial code onto a replica ladder. The leg then reads two comparator lines: one says the replica sits above the reference point, the other says it sits below. A successive-approximation search finds each leg's code. The finished codes go to the pads, either at full strength for termination or doubled for a half-impedance driver.

After reset the first search starts by itself. A startup hold output stalls the configuration sequencer until that first search completes. After that, the update mode decides what happens. In the tracking modes a one-step correction runs periodically. In the quiet mode nothing moves until the calibration-reset input is pulsed. Each pin also gets a termination enable. The enable is either always on, or on only while the pin's output buffer is 3-stated.

Top module: `imp_cal_ctrl`

## Requirements
- R1: While `rst` is high, both code outputs and both driver outputs are 0, `match_done_o` is 0 and `startup_hold_o` is 1. When `rst` falls, a full calibration starts with no other stimulus. It ends within CODE_W*(SETTLE_CYC+1) clocks.
- R2: A comparator line `*_hi_i`=1 means the trial code is above the reference point, and `*_lo_i`=1 means it is below. The search starts at the midpoint code 2^(CODE_W-1) and resolves one bit per step, MSB first. Each step holds the trial code for SETTLE_CYC clocks and then samples. If `*_hi_i` is 1 the bit is cleared, otherwise it is kept. The result is the largest code not reported as above the reference, or the maximum code if none is.
- R3: `upd_mode_i` encodes 2'b00 as the default tracking mode and 2'b10 as quiet. 2'b01 (continuous) and 2'b11 behave exactly like 2'b00.
- R4: In quiet mode, no background update takes place and the codes change only after a pulse on `cal_rst_i`.
- R5: `match_done_o` rises when the first full calibration commits and then stays high until `rst`. `startup_hold_o` is high exactly while `match_done_o` is low.
- R6: With `half_drv_i`=0 the driver codes equal the calibrated codes. With `half_drv_i`=1 each driver code is twice its calibrated code, saturated at 2^CODE_W-1. The termination codes `*_code_o` are unaffected by `half_drv_i`.
- R7: For each pin i, `term_en_o[i]` is 1 when `term_always_i[i]`=1. When `term_always_i[i]`=0, it is 1 only while `oe_i[i]`=0.
- R8: In a tracking mode, after TRACK_PERIOD idle clocks, a correction holds the current code for SETTLE_CYC clocks and samples once. It then moves each leg by +1 if `*_lo_i`, by -1 if `*_hi_i`, and holds if neither is set, saturating at 0 and at 2^CODE_W-1.
- R9: `pu_code_o` and `pd_code_o` change only in the cycle after a search's last step or after a correction. Intermediate trial values never appear on them.
- R10: A pulse on `cal_rst_i` at any time, including mid-search, restarts a full search from the midpoint. `match_done_o` stays high if it was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_rst_i | input | 1 | Calibration restart request |
| upd_mode_i | input | 2 | Update mode select |
| half_drv_i | input | 1 | Selects half-impedance driver codes |
| pu_hi_i | input | 1 | Pull-up replica above reference |
| pu_lo_i | input | 1 | Pull-up replica below reference |
| pd_hi_i | input | 1 | Pull-down replica above reference |
| pd_lo_i | input | 1 | Pull-down replica below reference |
| oe_i | input | N_PIN | Per-pin output buffer enable |
| term_always_i | input | N_PIN | Per-pin termination variant: 1 always on, 0 only when 3-stated |
| pu_trial_o | output | CODE_W | Pull-up code driven onto the replica ladder |
| pd_trial_o | output | CODE_W | Pull-down code driven onto the replica ladder |
| pu_code_o | output | CODE_W | Committed pull-up termination code |
| pd_code_o | output | CODE_W | Committed pull-down termination code |
| pu_drv_o | output | CODE_W | Pull-up driver code |
| pd_drv_o | output | CODE_W | Pull-down driver code |
| match_done_o | output | 1 | First calibration complete |
| startup_hold_o | output | 1 | Holds the startup sequencer |
| term_en_o | output | N_PIN | Per-pin split-termination enable |

## Verification
A restart request can land in the same cycle as a pending search step, while the sticky done flag is already set. The bench starts a search toward one target and moves the target about thirty clocks in. It then pulses the restart and samples every cycle after that. It judges that the done flag never drops, that the committed code never shows the half-finished value, and that the final code matches the new target rather than a mix of the two.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DECIDE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        UPD_ASREQ = 2'b00,
        UPD_CONT  = 2'b01,
        UPD_QUIET = 2'b10,
        UPD_SPARE = 2'b11
    } upd_mode_e;

    // Control word from the sequencer to each leg datapath
    typedef struct packed {
        logic load_mid;
        logic sar_step;
        logic last_bit;
        logic track_step;
    } leg_ctl_t;

    // Only quiet mode suppresses background correction
    function automatic logic tracking_allowed(input logic [1:0] mode);
        return mode != UPD_QUIET;
    endfunction

endpackage

// File: rtl/imp_cal_leg.sv
module imp_cal_leg
    import imp_cal_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  leg_ctl_t          ctl,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              cmp_hi_i,
    input  logic              cmp_lo_i,
    output logic [CODE_W-1:0] trial_o,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] trial_q, code_q;
    logic [CODE_W-1:0] cur_bit, nxt_bit, kept, tracked;

    always_comb begin
        cur_bit = ONE << bit_idx;
        nxt_bit = cur_bit >> 1;
        kept    = cmp_hi_i ? (trial_q & ~cur_bit) : trial_q;
        tracked = code_q;
        if (cmp_lo_i && !cmp_hi_i && code_q != MAXC)
            tracked = code_q + ONE;
        else if (cmp_hi_i && !cmp_lo_i && code_q != '0)
            tracked = code_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= MID;
            code_q  <= '0;
        end else if (ctl.load_mid) begin
            trial_q <= MID;
        end else if (ctl.sar_step) begin
            if (ctl.last_bit) begin
                trial_q <= kept;
                code_q  <= kept;
            end else begin
                trial_q <= kept | nxt_bit;
            end
        end else if (ctl.track_step) begin
            trial_q <= tracked;
            code_q  <= tracked;
        end
    end

    assign trial_o = trial_q;
    assign code_o  = code_q;
endmodule

// File: rtl/imp_cal_seq.sv
module imp_cal_seq
    import imp_cal_pkg::*;
#(
    parameter int CODE_W       = 7,
    parameter int IDX_W        = 3,
    parameter int SETTLE_CYC   = 8,
    parameter int TRACK_PERIOD = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_rst_i,
    input  logic [1:0]       upd_mode_i,
    output leg_ctl_t         ctl_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             match_done_o,
    output logic             track_launch_o
);
    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam int PER_W = (TRACK_PERIOD > 1) ? $clog2(TRACK_PERIOD) : 1;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(TRACK_PERIOD - 1);
    localparam logic [IDX_W-1:0] TOP_BIT  = IDX_W'(CODE_W - 1);

    seq_state_e       state_q;
    logic [SET_W-1:0] set_cnt_q;
    logic [PER_W-1:0] per_cnt_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic             is_track_q;
    logic             done_q;
    logic             decide;

    always_comb begin
        decide            = (state_q == ST_DECIDE);
        ctl_o.load_mid    = cal_rst_i;
        ctl_o.sar_step    = decide && !is_track_q && !cal_rst_i;
        ctl_o.track_step  = decide && is_track_q && !cal_rst_i;
        ctl_o.last_bit    = (bit_idx_q == '0);
        track_launch_o    = (state_q == ST_IDLE) && !cal_rst_i &&
                            tracking_allowed(upd_mode_i) && (per_cnt_q == PER_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_SETTLE;
            set_cnt_q  <= '0;
            per_cnt_q  <= '0;
            bit_idx_q  <= TOP_BIT;
            is_track_q <= 1'b0;
            done_q     <= 1'b0;
        end else if (cal_rst_i) begin
            state_q    <= ST_SETTLE;
            set_cnt_q  <= '0;
            per_cnt_q  <= '0;
            bit_idx_q  <= TOP_BIT;
            is_track_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!tracking_allowed(upd_mode_i)) begin
                        per_cnt_q <= '0;
                    end else if (track_launch_o) begin
                        state_q    <= ST_SETTLE;
                        set_cnt_q  <= '0;
                        per_cnt_q  <= '0;
                        is_track_q <= 1'b1;
                    end else begin
                        per_cnt_q <= per_cnt_q + PER_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (set_cnt_q == SET_LAST) state_q <= ST_DECIDE;
                    else                       set_cnt_q <= set_cnt_q + SET_W'(1);
                end
                ST_DECIDE: begin
                    if (is_track_q) begin
                        state_q    <= ST_IDLE;
                        is_track_q <= 1'b0;
                    end else if (bit_idx_q == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        bit_idx_q <= bit_idx_q - IDX_W'(1);
                        set_cnt_q <= '0;
                        state_q   <= ST_SETTLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bit_idx_o    = bit_idx_q;
    assign match_done_o = done_q;
endmodule

// File: rtl/imp_cal_term.sv
module imp_cal_term #(
    parameter int N_PIN = 4
) (
    input  logic [N_PIN-1:0] oe_i,
    input  logic [N_PIN-1:0] term_always_i,
    output logic [N_PIN-1:0] term_en_o
);
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        // always-present variant ignores direction; the other needs a 3-stated buffer
        assign term_en_o[p] = term_always_i[p] ? 1'b1 : ~oe_i[p];
    end
endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
    import imp_cal_pkg::*;
#(
    parameter int CODE_W       = 7,
    parameter int SETTLE_CYC   = 8,
    parameter int TRACK_PERIOD = 1024,
    parameter int N_PIN        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_rst_i,
    input  logic [1:0]        upd_mode_i,
    input  logic              half_drv_i,
    input  logic              pu_hi_i,
    input  logic              pu_lo_i,
    input  logic              pd_hi_i,
    input  logic              pd_lo_i,
    input  logic [N_PIN-1:0]  oe_i,
    input  logic [N_PIN-1:0]  term_always_i,
    output logic [CODE_W-1:0] pu_trial_o,
    output logic [CODE_W-1:0] pd_trial_o,
    output logic [CODE_W-1:0] pu_code_o,
    output logic [CODE_W-1:0] pd_code_o,
    output logic [CODE_W-1:0] pu_drv_o,
    output logic [CODE_W-1:0] pd_drv_o,
    output logic              match_done_o,
    output logic              startup_hold_o,
    output logic [N_PIN-1:0]  term_en_o
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int N_LEG = 2;
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

    leg_ctl_t         ctl;
    logic [IDX_W-1:0] bit_idx;
    logic             track_launch;
    logic             done;

    logic [N_LEG-1:0]  hi_a, lo_a;
    logic [CODE_W-1:0] trial_a [N_LEG];
    logic [CODE_W-1:0] code_a  [N_LEG];
    logic [CODE_W-1:0] drv_a   [N_LEG];

    assign hi_a = {pd_hi_i, pu_hi_i};
    assign lo_a = {pd_lo_i, pu_lo_i};

    imp_cal_seq #(
        .CODE_W(CODE_W), .IDX_W(IDX_W),
        .SETTLE_CYC(SETTLE_CYC), .TRACK_PERIOD(TRACK_PERIOD)
    ) u_seq (
        .clk(clk), .rst(rst), .cal_rst_i(cal_rst_i), .upd_mode_i(upd_mode_i),
        .ctl_o(ctl), .bit_idx_o(bit_idx), .match_done_o(done),
        .track_launch_o(track_launch)
    );

    for (genvar g = 0; g < N_LEG; g++) begin : g_leg
        logic [CODE_W:0] dbl;

        imp_cal_leg #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_leg (
            .clk(clk), .rst(rst), .ctl(ctl), .bit_idx(bit_idx),
            .cmp_hi_i(hi_a[g]), .cmp_lo_i(lo_a[g]),
            .trial_o(trial_a[g]), .code_o(code_a[g])
        );

        // two parallel driver segments: double, clamp at full scale
        assign dbl      = {code_a[g], 1'b0};
        assign drv_a[g] = !half_drv_i ? code_a[g] :
                          (dbl[CODE_W] ? MAXC : dbl[CODE_W-1:0]);
    end

    imp_cal_term #(.N_PIN(N_PIN)) u_term (
        .oe_i(oe_i), .term_always_i(term_always_i), .term_en_o(term_en_o)
    );

    assign pu_trial_o     = trial_a[0];
    assign pd_trial_o     = trial_a[1];
    assign pu_code_o      = code_a[0];
    assign pd_code_o      = code_a[1];
    assign pu_drv_o       = drv_a[0];
    assign pd_drv_o       = drv_a[1];
    assign match_done_o   = done;
    assign startup_hold_o = ~done;
endmodule

// File: rtl/imp_cal_chk.sv
module imp_cal_chk
    import imp_cal_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int N_PIN  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cal_rst_i,
    input logic [1:0]        upd_mode_i,
    input logic              half_drv_i,
    input logic [N_PIN-1:0]  oe_i,
    input logic [N_PIN-1:0]  term_always_i,
    input logic [N_PIN-1:0]  term_en_o,
    input logic [CODE_W-1:0] pu_trial_o,
    input logic [CODE_W-1:0] pu_code_o,
    input logic [CODE_W-1:0] pd_code_o,
    input logic [CODE_W-1:0] pu_drv_o,
    input logic [CODE_W-1:0] pd_drv_o,
    input logic              match_done_o,
    input logic              startup_hold_o,
    input leg_ctl_t          ctl,
    input logic              track_launch
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        match_done_o |=> match_done_o);

    p_hold_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(match_done_o) |-> $fell(startup_hold_o));

    p_quiet_no_launch_r4: assert property (@(posedge clk) disable iff (rst)
        track_launch |-> (upd_mode_i != UPD_QUIET));

    p_restart_mid_r10: assert property (@(posedge clk) disable iff (rst)
        cal_rst_i |=> (pu_trial_o == MID));

    p_commit_only_r9: assert property (@(posedge clk) disable iff (rst)
        (!(ctl.sar_step && ctl.last_bit) && !ctl.track_step)
        |=> ($stable(pu_code_o) && $stable(pd_code_o)));

    p_track_one_step_r8: assert property (@(posedge clk) disable iff (rst)
        ctl.track_step |=> (pu_code_o == $past(pu_code_o) ||
                            pu_code_o == $past(pu_code_o) + ONE ||
                            pu_code_o == $past(pu_code_o) - ONE));

    p_drv_full_r6: assert property (@(posedge clk) disable iff (rst)
        !half_drv_i |-> (pu_drv_o == pu_code_o && pd_drv_o == pd_code_o));

    p_drv_half_r6: assert property (@(posedge clk) disable iff (rst)
        half_drv_i |-> (pu_drv_o >= pu_code_o && pd_drv_o >= pd_code_o));

    p_term_3state_r7: assert property (@(posedge clk) disable iff (rst)
        ((oe_i & ~term_always_i & term_en_o) == '0));

    p_term_always_r7: assert property (@(posedge clk) disable iff (rst)
        ((term_always_i & ~term_en_o) == '0));
endmodule

bind imp_cal_ctrl imp_cal_chk #(.CODE_W(CODE_W), .N_PIN(N_PIN)) u_chk (
    .clk(clk), .rst(rst), .cal_rst_i(cal_rst_i), .upd_mode_i(upd_mode_i),
    .half_drv_i(half_drv_i), .oe_i(oe_i), .term_always_i(term_always_i),
    .term_en_o(term_en_o), .pu_trial_o(pu_trial_o), .pu_code_o(pu_code_o),
    .pd_code_o(pd_code_o), .pu_drv_o(pu_drv_o), .pd_drv_o(pd_drv_o),
    .match_done_o(match_done_o), .startup_hold_o(startup_hold_o),
    .ctl(ctl), .track_launch(track_launch)
);

// File: tb/tb_imp_cal_ctrl.sv
module tb_imp_cal_ctrl;
    localparam int CLK_P  = 10;
    localparam int CODE_W = 7;
    localparam int N_PIN  = 4;
    localparam int MAXC   = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst, cal_rst, half_drv;
    logic [1:0] mode;
    logic pu_hi, pu_lo, pd_hi, pd_lo;
    logic [N_PIN-1:0] oe, t_always, term_en;
    logic [CODE_W-1:0] pu_trial, pd_trial, pu_code, pd_code, pu_drv, pd_drv;
    logic done, hold;
    int tgt_pu, tgt_pd;
    int n_chk = 0, n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    // replica ladder + comparator model
    always_comb begin
        pu_hi = int'(pu_trial) > tgt_pu;
        pu_lo = int'(pu_trial) < tgt_pu;
        pd_hi = int'(pd_trial) > tgt_pd;
        pd_lo = int'(pd_trial) < tgt_pd;
    end

    imp_cal_ctrl #(.CODE_W(CODE_W), .N_PIN(N_PIN)) dut (
        .clk(clk), .rst(rst), .cal_rst_i(cal_rst), .upd_mode_i(mode),
        .half_drv_i(half_drv), .pu_hi_i(pu_hi), .pu_lo_i(pu_lo),
        .pd_hi_i(pd_hi), .pd_lo_i(pd_lo), .oe_i(oe), .term_always_i(t_always),
        .pu_trial_o(pu_trial), .pd_trial_o(pd_trial), .pu_code_o(pu_code),
        .pd_code_o(pd_code), .pu_drv_o(pu_drv), .pd_drv_o(pd_drv),
        .match_done_o(done), .startup_hold_o(hold), .term_en_o(term_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int clamp(input int v);
        return (v > MAXC) ? MAXC : ((v < 0) ? 0 : v);
    endfunction

    task automatic recal(input int tu, input int td);
        tgt_pu = tu; tgt_pd = td;
        cal_rst = 1'b1; tick(1); cal_rst = 1'b0;
        tick(75);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cal_rst = 1'b0; half_drv = 1'b0; mode = 2'b10;
        oe = '0; t_always = '0; tgt_pu = 37; tgt_pd = 90;
        tick(3);
        // R1 reset state
        check("R1 pu_code in reset", pu_code, 0);
        check("R1 pd_code in reset", pd_code, 0);
        check("R1 pu_drv in reset", pu_drv, 0);
        check("R5 match_done in reset", done, 0);
        check("R5 hold in reset", hold, 1);
        rst = 1'b0;
        tick(20);
        check("R5 hold during first search", hold, 1);
        check("R9 code untouched mid-search", pu_code, 0);
        tick(60);
        check("R1 auto calibration pu", pu_code, 37);
        check("R1 auto calibration pd", pd_code, 90);
        check("R5 match_done after first", done, 1);
        check("R5 hold released", hold, 0);

        // R2/R6 sweep all codes, plus an out-of-range target
        for (int t = 0; t <= MAXC + 1; t++) begin
            recal(t, MAXC - t);
            check("R2 search pu", pu_code, clamp(t));
            check("R2 search pd", pd_code, clamp(MAXC - t));
            check("R6 full drv pu", pu_drv, pu_code);
            half_drv = 1'b1; #1;
            check("R6 half drv pu", pu_drv, clamp(2 * clamp(t)));
            check("R6 half drv pd", pd_drv, clamp(2 * clamp(MAXC - t)));
            check("R6 term code unchanged", pu_code, clamp(t));
            half_drv = 1'b0;
            check("R5 done stays", done, 1);
        end

        // R4 quiet mode ignores reference drift
        recal(30, 60);
        tgt_pu = 40; tgt_pd = 55;
        tick(3000);
        check("R4 quiet pu held", pu_code, 30);
        check("R4 quiet pd held", pd_code, 60);
        recal(40, 55);
        check("R4 quiet recal pu", pu_code, 40);

        // R8 tracking in default mode, one step per period
        recal(50, 77);
        mode = 2'b00; tgt_pu = 53; tgt_pd = 75;
        tick(1100);
        check("R8 first step pu", pu_code, 51);
        check("R8 first step pd", pd_code, 76);
        tick(3000);
        check("R8 tracked pu", pu_code, 53);
        check("R8 tracked pd", pd_code, 75);

        // R3 continuous and spare encodings track like default
        mode = 2'b01; tgt_pu = 55;
        tick(2200);
        check("R3 continuous tracks", pu_code, 55);
        mode = 2'b11; tgt_pu = 54;
        tick(1200);
        check("R3 spare code tracks", pu_code, 54);

        // R8 saturation at full scale
        mode = 2'b10;
        recal(MAXC, 0);
        mode = 2'b00; tgt_pu = MAXC + 50; tgt_pd = -5;
        tick(2200);
        check("R8 saturate high", pu_code, MAXC);
        check("R8 saturate low", pd_code, 0);

        // R9 no partial values during a recalibration
        mode = 2'b10;
        recal(20, 20);
        begin
            bit bad = 0;
            tgt_pu = 100; tgt_pd = 100;
            cal_rst = 1'b1; tick(1); cal_rst = 1'b0;
            for (int c = 0; c < 75; c++) begin
                if (pu_code != 20 && pu_code != 100) bad = 1;
                tick(1);
            end
            check("R9 only old or new code seen", bad, 0);
            check("R9 final code", pu_code, 100);
        end

        // R10 restart mid-search, done held
        begin
            bit dropped = 0;
            tgt_pu = 10; tgt_pd = 10;
            cal_rst = 1'b1; tick(1); cal_rst = 1'b0;
            for (int c = 0; c < 30; c++) begin
                if (!done) dropped = 1;
                tick(1);
            end
            tgt_pu = 100; tgt_pd = 5;
            cal_rst = 1'b1; tick(1); cal_rst = 1'b0;
            check("R10 trial at midpoint", pu_trial, 64);
            for (int c = 0; c < 75; c++) begin
                if (!done) dropped = 1;
                tick(1);
            end
            check("R10 done never dropped", dropped, 0);
            check("R10 restarted pu", pu_code, 100);
            check("R10 restarted pd", pd_code, 5);
        end

        // R7 exhaustive termination enables
        for (int a = 0; a < (1 << N_PIN); a++) begin
            for (int o = 0; o < (1 << N_PIN); o++) begin
                t_always = N_PIN'(a); oe = N_PIN'(o); #1;
                check("R7 term enables", term_en, (a | ~o) & ((1 << N_PIN) - 1));
            end
        end

        finish_run();
    end
endmodule